// File: doc/BRIEF.md
# Byte-Stream Accumulator Execution Core

This block is a small sequential execution core that reads its program one byte at a time from a byte-wide, synchronous program memory. It interprets a very small subset of a classic 32-bit instruction set. The core holds eight 32-bit general registers, a 32-bit instruction pointer and three status flags: overflow, zero and sign. The only arithmetic instruction adds a 32-bit immediate to the accumulator (register 0). The immediate is assembled from four stream bytes, least significant byte first. A halt opcode ends the run. Two prefix bytes open second-level and third-level opcode lookups. Neither of those levels holds any instruction yet, so every byte reached there is rejected.

After reset the core waits for a start pulse. On start the instruction pointer is set to 1, because address 0 is kept as a null location. The core then runs until it halts. Any byte that matches no opcode at its level stops the core and raises a sticky error. A fetch at or past the program length returns the halt byte and does not read memory. A debug port lets the surrounding logic read any register, the flags and the instruction pointer at any time.

Top module: `byte_exec_core`

## Requirements
- R1: After reset all eight registers, the instruction pointer and the three flags read zero, and halted and error are low.
- R2: A start pulse while idle sets the instruction pointer to 1, so the first memory read is at address 1.
- R3: Opcode 0x05 takes the next four stream bytes as a 32-bit immediate, least significant byte first, and adds it to register 0 with 32-bit wrap-around. Registers 1 to 7 keep their values.
- R4: After an add, the sign flag equals bit 31 of the result, and the zero flag is set exactly when the result is zero.
- R5: After an add, the overflow flag is set exactly when the true signed sum of the two operands differs from the wrapped 32-bit result.
- R6: A fetch while the instruction pointer is at or above the program length delivers the byte 0xF4, issues no memory read and leaves the instruction pointer unchanged. This holds for immediate bytes too.
- R7: Opcode 0xF4 at the first level sets the instruction pointer to the program length and raises halted with error low. Bytes after it are not executed.
- R8: After the first-level byte 0x0F, every second byte is rejected: halted and error rise, and register 0 is unchanged.
- R9: After the first-level byte 0xF3, a second byte of 0x0F leads to a third fetch, and that third byte is rejected. Any other second byte, 0xF4 included, is rejected at once.
- R10: Any first-level byte other than 0x05, 0x0F, 0xF3 or 0xF4 is rejected. A rejection raises error and halted in the same cycle. Error then stays set, and start has no effect, until reset.
- R11: Every byte takes two clock cycles: one to issue the fetch and one to use the returned data. Halted is visible 1 + 2·B cycles after the cycle in which start is sampled, where B is the number of bytes fetched, counting the synthesized halt bytes.
- R12: The debug port returns the register whose index is placed on dbgSel. The index order is accumulator 0, then counter, data, base, stack pointer, base pointer, source and destination as 1 to 7. dbgFlags carries overflow in bit 2, zero in bit 1 and sign in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 1 when idle |
| progLen | input | 32 | Program length in bytes (address 0 included) |
| memRd | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address (instruction pointer) |
| memData | input | 8 | Read data, valid one cycle after memRd |
| halted | output | 1 | Core has stopped |
| error | output | 1 | Sticky rejected-opcode indicator |
| dbgSel | input | 3 | Debug register index |
| dbgReg | output | 32 | Selected register value |
| dbgFlags | output | 3 | {overflow, zero, sign} |
| dbgIp | output | 32 | Instruction pointer |

## Verification
The bench targets an immediate cut short by the program end. A core that read memory past the end, or that stopped early, would put garbage or zero bytes into the accumulator in place of the 0xF4 bytes. It runs both signed overflow directions and a sum that lands exactly on zero. A core that took overflow from the carry, or missed the zero case, would report wrong flags. It covers every rejection level and a halt byte placed at the second level. A core that treated 0xF4 as valid after a prefix, or that read no third byte after 0xF3 0x0F, would halt cleanly or show the wrong cycle count. Error stickiness across a second start is checked, as are random multi-add programs against a reference sum.

// File: rtl/bec_pkg.sv
package bec_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 8;
  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int IMM_BYTES = DATA_W / 8;
  localparam int IMM_IDX_W = $clog2(IMM_BYTES);
  localparam int ACC_IDX   = 0;

  localparam logic [7:0] OP_ADD_ACC = 8'h05;
  localparam logic [7:0] OP_ESCAPE  = 8'h0F;
  localparam logic [7:0] OP_REPEAT  = 8'hF3;
  localparam logic [7:0] OP_HALT    = 8'hF4;

  typedef struct packed {
    logic                 ipSetOne;
    logic                 ipInc;
    logic                 ipSetLen;
    logic                 immLoad;
    logic [IMM_IDX_W-1:0] immIdx;
    logic                 addExec;
  } bec_strobe_t;
endpackage

// File: rtl/bec_ctrl.sv
module bec_ctrl
  import bec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        ipAtEnd,
  input  logic [7:0]  memData,
  output bec_strobe_t strobe,
  output logic        memRd,
  output logic [7:0]  fetchByte,
  output logic        halted,
  output logic        error
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;
  typedef enum logic [2:0] {C_OP1, C_ESC, C_REP, C_REP_ESC, C_IMM} ctx_t;

  state_t state, stateN;
  ctx_t ctx, ctxN;
  logic [IMM_IDX_W-1:0] immCnt, immCntN;
  logic haltPend, haltPendN;
  logic errorN;

  always_comb begin
    strobe    = '0;
    memRd     = 1'b0;
    stateN    = state;
    ctxN      = ctx;
    immCntN   = immCnt;
    haltPendN = haltPend;
    errorN    = error;
    fetchByte = haltPend ? OP_HALT : memData;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.ipSetOne = 1'b1;
          stateN = S_ISSUE;
          ctxN   = C_OP1;
        end
      end
      S_ISSUE: begin
        memRd        = !ipAtEnd;
        strobe.ipInc = !ipAtEnd;
        haltPendN    = ipAtEnd;
        stateN       = S_WAIT;
      end
      S_WAIT: begin
        stateN = S_ISSUE;
        unique case (ctx)
          C_OP1: begin
            if (fetchByte == OP_ADD_ACC) begin
              ctxN    = C_IMM;
              immCntN = '0;
            end else if (fetchByte == OP_ESCAPE) begin
              ctxN = C_ESC;
            end else if (fetchByte == OP_REPEAT) begin
              ctxN = C_REP;
            end else if (fetchByte == OP_HALT) begin
              strobe.ipSetLen = 1'b1;
              stateN = S_DONE;
            end else begin
              errorN = 1'b1;
              stateN = S_DONE;
            end
          end
          C_REP: begin
            if (fetchByte == OP_ESCAPE) begin
              ctxN = C_REP_ESC;
            end else begin
              errorN = 1'b1;
              stateN = S_DONE;
            end
          end
          C_IMM: begin
            strobe.immLoad = 1'b1;
            strobe.immIdx  = immCnt;
            if (immCnt == IMM_IDX_W'(IMM_BYTES - 1)) begin
              strobe.addExec = 1'b1;
              ctxN = C_OP1;
            end else begin
              immCntN = immCnt + 1'b1;
            end
          end
          default: begin
            errorN = 1'b1;
            stateN = S_DONE;
          end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ctx      <= C_OP1;
      immCnt   <= '0;
      haltPend <= 1'b0;
      error    <= 1'b0;
    end else begin
      state    <= stateN;
      ctx      <= ctxN;
      immCnt   <= immCntN;
      haltPend <= haltPendN;
      error    <= errorN;
    end
  end

  assign halted = (state == S_DONE);

  // R11: a read is never issued in two consecutive cycles
  a_r11_one_read_per_two: assert property (@(posedge clk) disable iff (rst)
    memRd |=> !memRd);
  // R10: error never clears without reset
  a_r10_error_sticky: assert property (@(posedge clk) disable iff (rst)
    error |=> error);
  // R10: error always comes with halted
  a_r10_error_halts: assert property (@(posedge clk) disable iff (rst)
    error |-> halted);
endmodule

// File: rtl/bec_datapath.sv
module bec_datapath
  import bec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  bec_strobe_t          strobe,
  input  logic [7:0]           fetchByte,
  input  logic [ADDR_W-1:0]    progLen,
  output logic [ADDR_W-1:0]    memAddr,
  output logic                 ipAtEnd,
  input  logic [REG_IDX_W-1:0] dbgSel,
  output logic [DATA_W-1:0]    dbgReg,
  output logic [2:0]           dbgFlags,
  output logic [ADDR_W-1:0]    dbgIp
);
  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic [ADDR_W-1:0] ip;
  logic [DATA_W-1:0] immReg;
  logic [DATA_W-1:0] immFull;
  logic [DATA_W-1:0] sumRes;
  logic [DATA_W:0]   sumWide;
  logic flagOf, flagZf, flagSf;

  // immediate including the byte arriving this cycle
  always_comb begin
    immFull = immReg;
    immFull[8*strobe.immIdx +: 8] = fetchByte;
  end

  always_ff @(posedge clk) begin
    if (rst) immReg <= '0;
    else if (strobe.immLoad) immReg <= immFull;
  end

  assign sumWide = {regFile[ACC_IDX][DATA_W-1], regFile[ACC_IDX]}
                 + {immFull[DATA_W-1], immFull};
  assign sumRes  = sumWide[DATA_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regFile[g] <= '0;
      else if (strobe.addExec && (g == ACC_IDX)) regFile[g] <= sumRes;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagOf <= 1'b0;
      flagZf <= 1'b0;
      flagSf <= 1'b0;
    end else if (strobe.addExec) begin
      flagOf <= sumWide[DATA_W] ^ sumWide[DATA_W-1];
      flagZf <= (sumRes == '0);
      flagSf <= sumRes[DATA_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ip <= '0;
    else if (strobe.ipSetOne) ip <= ADDR_W'(1);
    else if (strobe.ipSetLen) ip <= progLen;
    else if (strobe.ipInc) ip <= ip + 1'b1;
  end

  assign memAddr  = ip;
  assign ipAtEnd  = (ip >= progLen);
  assign dbgReg   = regFile[dbgSel];
  assign dbgFlags = {flagOf, flagZf, flagSf};
  assign dbgIp    = ip;

  // R6: the pointer only advances below the program length
  a_r6_inc_below_len: assert property (@(posedge clk) disable iff (rst)
    strobe.ipInc |-> (ip < progLen));
  // R4: zero flag agrees with the stored accumulator after an add
  a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst)
    strobe.addExec |=> (flagZf == (regFile[ACC_IDX] == '0)));
  // R7: halt lands the pointer on the program length
  a_r7_halt_ip: assert property (@(posedge clk) disable iff (rst)
    strobe.ipSetLen |=> (ip == $past(progLen)));
endmodule

// File: rtl/byte_exec_core.sv
module byte_exec_core
  import bec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] progLen,
  output logic        memRd,
  output logic [31:0] memAddr,
  input  logic [7:0]  memData,
  output logic        halted,
  output logic        error,
  input  logic [2:0]  dbgSel,
  output logic [31:0] dbgReg,
  output logic [2:0]  dbgFlags,
  output logic [31:0] dbgIp
);
  bec_strobe_t strobe;
  logic ipAtEnd;
  logic [7:0] fetchByte;

  bec_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .ipAtEnd(ipAtEnd), .memData(memData),
    .strobe(strobe), .memRd(memRd), .fetchByte(fetchByte),
    .halted(halted), .error(error)
  );

  bec_datapath #(.ADDR_W(32)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .fetchByte(fetchByte),
    .progLen(progLen), .memAddr(memAddr), .ipAtEnd(ipAtEnd),
    .dbgSel(dbgSel), .dbgReg(dbgReg), .dbgFlags(dbgFlags), .dbgIp(dbgIp)
  );

  // R6: memory is never read at or past the program end
  a_r6_no_read_past_len: assert property (@(posedge clk) disable iff (rst)
    memRd |-> (memAddr < progLen));
endmodule

// File: tb/byte_exec_core_bench.sv
module byte_exec_core_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] progLen = 32'd1;
  logic memRd;
  logic [31:0] memAddr;
  logic [7:0] memData;
  logic halted, error;
  logic [2:0] dbgSel = 3'd0;
  logic [31:0] dbgReg;
  logic [2:0] dbgFlags;
  logic [31:0] dbgIp;

  logic [7:0] mem [256];
  int tests = 0;
  int fails = 0;
  int runCycles;
  logic [31:0] firstAddr;
  logic sawRead;

  always #2 clk = ~clk;

  byte_exec_core u_byte_exec_core (
    .clk(clk), .rst(rst), .start(start), .progLen(progLen),
    .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .halted(halted), .error(error), .dbgSel(dbgSel),
    .dbgReg(dbgReg), .dbgFlags(dbgFlags), .dbgIp(dbgIp)
  );

  always_ff @(posedge clk) begin
    if (memRd) memData <= mem[memAddr[7:0]];
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic put_imm(inout int pos, input logic [31:0] v);
    mem[pos] = 8'h05;
    for (int k = 0; k < 4; k++) mem[pos + 1 + k] = v[8*k +: 8];
    pos += 5;
  endtask

  // reset, then start the program in mem[] of length len
  task automatic run_prog(input int len);
    do_reset();
    progLen = len;
    sawRead = 1'b0;
    firstAddr = '0;
    runCycles = 0;
    start = 1'b1;
    @(posedge clk);
    runCycles = 1;
    @(negedge clk);
    start = 1'b0;
    while (!halted && runCycles < 3000) begin
      if (memRd && !sawRead) begin
        sawRead = 1'b1;
        firstAddr = memAddr;
      end
      @(posedge clk);
      runCycles++;
      @(negedge clk);
    end
    if (!halted) begin
      fails++;
      tests++;
      $display("FAIL run did not halt actual=0 expected=1");
    end
  endtask

  task automatic model_add(input logic [31:0] a, input logic [31:0] b,
                           output logic [31:0] r, output logic [2:0] fl);
    longint tmp;
    tmp = longint'($signed(a)) + longint'($signed(b));
    r = tmp[31:0];
    fl[2] = (tmp != longint'($signed(r)));
    fl[1] = (r == 32'd0);
    fl[0] = r[31];
  endtask

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbgSel = idx[2:0];
    #1;
    v = dbgReg;
  endtask

  initial begin
    #800000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, expAcc;
    logic [2:0] expFl;
    int pos;
    int seed;
    seed = 17;
    void'($urandom(seed));

    // R1 reset state, R12 debug indexing
    do_reset();
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      read_reg(i, v);
      check("R1 reg after reset", v, 32'd0);
    end
    check("R1 flags after reset", {29'd0, dbgFlags}, 32'd0);
    check("R1 ip after reset", dbgIp, 32'd0);
    check("R1 halted/error after reset", {30'd0, halted, error}, 32'd0);

    // R3 basic add, R2 first address, R6 implicit halt, R7, R11
    clear_mem();
    pos = 1;
    put_imm(pos, 32'h0d0c0b0a);
    run_prog(pos);
    read_reg(0, v);
    check("R3 accumulator little-endian", v, 32'h0d0c0b0a);
    check("R2 first read address", firstAddr, 32'd1);
    check("R4 flags plain add", {29'd0, dbgFlags}, 32'd0);
    check("R7 ip at length after halt", dbgIp, 32'd6);
    check("R7 no error on halt", {31'd0, error}, 32'd0);
    check("R11 cycles for 6 bytes", runCycles, 32'd13);
    for (int i = 1; i < 8; i++) begin
      read_reg(i, v);
      check("R3 other register unchanged", v, 32'd0);
    end

    // R4 zero result with explicit halt at the end
    clear_mem();
    pos = 1;
    put_imm(pos, 32'hffffffff);
    put_imm(pos, 32'h00000001);
    mem[pos] = 8'hF4;
    run_prog(pos + 1);
    read_reg(0, v);
    check("R4 zero sum", v, 32'd0);
    check("R4 zero flag set, sign clear", {29'd0, dbgFlags}, 32'b010);
    check("R7 explicit halt ip", dbgIp, pos + 1);

    // R7 halt in the middle stops execution
    clear_mem();
    mem[1] = 8'hF4;
    pos = 2;
    put_imm(pos, 32'h12345678);
    run_prog(pos);
    read_reg(0, v);
    check("R7 bytes after halt not executed", v, 32'd0);
    check("R7 mid-program halt ip", dbgIp, pos);
    check("R11 single halt byte cycles", runCycles, 32'd3);

    // R5 positive overflow
    clear_mem();
    pos = 1;
    put_imm(pos, 32'h7fffffff);
    put_imm(pos, 32'h00000001);
    run_prog(pos);
    read_reg(0, v);
    check("R5 positive overflow result", v, 32'h80000000);
    check("R5 overflow and sign flags", {29'd0, dbgFlags}, 32'b101);

    // R5 negative overflow to zero
    clear_mem();
    pos = 1;
    put_imm(pos, 32'h80000000);
    put_imm(pos, 32'h80000000);
    run_prog(pos);
    read_reg(0, v);
    check("R5 negative overflow result", v, 32'd0);
    check("R5 overflow and zero flags", {29'd0, dbgFlags}, 32'b110);

    // R6 immediate cut short by program end
    clear_mem();
    mem[1] = 8'h05;
    mem[2] = 8'h0a;
    mem[3] = 8'h77;
    run_prog(3);
    read_reg(0, v);
    check("R6 truncated immediate padded with F4", v, 32'hF4F4F40A);
    check("R6 sign flag of padded add", {29'd0, dbgFlags}, 32'b001);
    check("R6 ip held at length", dbgIp, 32'd3);
    check("R11 truncated program cycles", runCycles, 32'd13);

    // R8 escape prefix rejects its second byte
    clear_mem();
    mem[1] = 8'h0F;
    mem[2] = 8'h05;
    run_prog(3);
    read_reg(0, v);
    check("R8 escape error", {30'd0, halted, error}, 32'b11);
    check("R8 accumulator unchanged", v, 32'd0);
    clear_mem();
    mem[1] = 8'h0F;
    run_prog(2);
    check("R8 escape at end rejects F4", {30'd0, halted, error}, 32'b11);

    // R9 repeat prefix paths
    clear_mem();
    mem[1] = 8'hF3;
    mem[2] = 8'h05;
    run_prog(3);
    check("R9 repeat then other byte error", {31'd0, error}, 32'd1);
    check("R11 repeat reject cycles", runCycles, 32'd5);
    clear_mem();
    mem[1] = 8'hF3;
    mem[2] = 8'h0F;
    mem[3] = 8'h90;
    run_prog(4);
    check("R9 third byte rejected", {30'd0, halted, error}, 32'b11);
    check("R9 third byte fetched (cycles)", runCycles, 32'd7);
    clear_mem();
    mem[1] = 8'hF3;
    mem[2] = 8'hF4;
    run_prog(3);
    check("R9 halt at second level rejected", {31'd0, error}, 32'd1);

    // R10 unknown first byte, sticky error, start ignored
    clear_mem();
    pos = 1;
    put_imm(pos, 32'h00000003);
    mem[pos] = 8'h90;
    run_prog(pos + 1);
    check("R10 unknown opcode error+halt", {30'd0, halted, error}, 32'b11);
    read_reg(0, v);
    check("R10 earlier add kept", v, 32'd3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) @(negedge clk);
    check("R10 error sticky after start", {30'd0, halted, error}, 32'b11);
    read_reg(0, v);
    check("R10 start has no effect", v, 32'd3);
    do_reset();
    @(negedge clk);
    check("R10 reset clears error", {30'd0, halted, error}, 32'd0);

    // random multi-add programs
    for (int t = 0; t < 20; t++) begin
      int n;
      logic [31:0] imm;
      int oth;
      clear_mem();
      n = 1 + int'($urandom_range(5));
      pos = 1;
      expAcc = 32'd0;
      expFl = 3'd0;
      for (int k = 0; k < n; k++) begin
        case ($urandom_range(3))
          0: imm = 32'h7fffffff;
          1: imm = 32'h80000000;
          default: imm = $urandom();
        endcase
        put_imm(pos, imm);
        model_add(expAcc, imm, expAcc, expFl);
      end
      run_prog(pos);
      read_reg(0, v);
      check("R3 random accumulator", v, expAcc);
      check("R5 random flags", {29'd0, dbgFlags}, {29'd0, expFl});
      check("R11 random cycles", runCycles, 1 + 2 * (5 * n + 1));
      oth = 1 + int'($urandom_range(6));
      read_reg(oth, v);
      check("R12 random other register", v, 32'd0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule